// File: doc/BRIEF.md
# Configurable Serial Transmitter with Register Control

This block is the transmit half of an asynchronous serial port, driven through a small word-addressed register set. Software chooses the character length, the parity mode and the stop-bit length in a frame register. It turns the transmitter on or off with write-one command bits, and it queues characters into a two-entry buffer through a data register. An external generator supplies a baud tick at sixteen times the bit rate. Every serial bit lasts sixteen ticks, except the shorter or longer stop periods.

Software sees three live status bits: transmitter enabled, buffer level and transmission complete. A separate flag register latches the buffer-level and complete events, and software can also set or clear any flag directly. An enable mask selects which flags drive the single interrupt output. The meaning of the buffer-level bit depends on a control bit. It can mean "buffer completely empty" or "at least one slot free", so software can pick between refilling early or refilling in bursts.

Top module: `sertx_top`

## Requirements
- R1: After reset `tx_out` is 1, `irq` is 0, the status register (address 3) reads 0x0040 and the frame register (address 1) reads 0x1005 (8 data bits, no parity, one stop bit).
- R2: Frame bits 3:0 hold the character length minus three: codes 2..5 give 5..8 bits, codes 0..1 give 5 bits and codes 6..15 give 8 bits. A frame is a low start bit followed by the data bits, least significant first, and each lasts 16 baud ticks.
- R3: Frame bits 9:8 select parity: 00 and 01 send none, 10 sends even and 11 sends odd parity. The parity bit covers the data bits only and follows the last data bit.
- R4: Frame bits 13:12 select the high stop period: 00 lasts 8 ticks, 01 lasts 16, 10 lasts 24 and 11 lasts 32. The next queued frame starts right after it.
- R5: A write to the command register (address 2) with bit 2 set enables the transmitter, and bit 3 disables it. If both are set, disable wins. Status bit 1 shows the enabled state. While disabled no new frame starts, the line stays high and queued characters are kept.
- R6: Writes to address 4 queue bits 7:0 into a 2-entry first-in first-out buffer. A write while the buffer is full is dropped and leaves the queued entries unchanged.
- R7: Control register (address 0) bit 12 selects the meaning of status bit 6. With 0 it is 1 when the buffer is not full. With 1 it is 1 only when the buffer is empty.
- R8: Status bit 5 (transmission complete) becomes 1 after the last stop tick of a frame if the buffer is then empty. An accepted data write clears it.
- R9: The flag register (address 5) has bit 0 for complete, bit 1 for buffer level, and bits 2 and 4 that only software sets; bit 3 always reads 0. A write to address 6 sets the flags given as ones, and a write to address 7 clears them. Hardware sets bit 0 when status bit 5 is set, and sets bit 1 in every cycle that status bit 6 is 1. A hardware set wins over a clear.
- R10: `irq` is 1 from the cycle after any flag and its enable bit (address 8, same bit positions) are both 1. It is 0 from the cycle after none are.
- R11: `rd_data` shows the register selected by `rd_addr` one cycle later. Unused fields and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Registered read data |
| tx_out | output | 1 | Serial line, idle high |
| irq | output | 1 | Interrupt request |

## Verification
Register reads are due one cycle after the address is presented, so the bench applies the address on a falling edge and samples on the next falling edge. A data write with the transmitter enabled moves the line low two rising edges later. The serial monitor then samples each bit at its midpoint, a multiple of 64 clocks after the falling edge, and leaves a half-bit margin for tick alignment. Stop lengths are checked as start-to-start spacing of back-to-back frames, within a few clocks of the tick count times four. Interrupt changes are sampled two edges after the causing write, because the flag and the request are each one register stage.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;
  localparam int FW     = 5;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_FRAME  = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_CMD    = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_TXDATA = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_FLAG   = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_FSET   = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_FCLR   = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_FEN    = 4'd8;

  localparam int CMD_ON     = 2;
  localparam int CMD_OFF    = 3;
  localparam int ST_ON      = 1;
  localparam int ST_DONE    = 5;
  localparam int ST_LVL     = 6;
  localparam int CTRL_LVL   = 12;
  localparam int FL_DONE    = 0;
  localparam int FL_LVL     = 1;

  localparam logic [REG_W-1:0] CTRL_MASK  = 16'h1000;
  localparam logic [REG_W-1:0] FRAME_MASK = 16'h330F;
  localparam logic [REG_W-1:0] FRAME_RST  = 16'h1005;
  localparam logic [FW-1:0]    FLAG_MASK  = 5'b10111;

  typedef struct packed {
    logic [2:0] len_m1;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop_sel;
  } frame_cfg_t;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} tx_state_e;

  function automatic frame_cfg_t decode_frame(input logic [REG_W-1:0] v);
    frame_cfg_t c;
    if (v[3:0] < 4'd2)      c.len_m1 = 3'd4;
    else if (v[3:0] > 4'd5) c.len_m1 = 3'd7;
    else                    c.len_m1 = 3'(v[3:0] + 4'd2);
    c.par_en   = v[9];
    c.par_odd  = v[9] & v[8];
    c.stop_sel = v[13:12];
    return c;
  endfunction
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign count   = cnt_q;
  assign dout    = mem[rptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= nxt(wptr_q);
      if (pop_ok)  rptr_q <= nxt(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R6: a write into a full buffer leaves the occupancy unchanged
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q)));
  // R6: the transmitter never pulls from an empty buffer
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter import sertx_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       tx_en,
  input  logic       have_data,
  input  logic [7:0] din,
  input  frame_cfg_t cfg,
  output logic       pop,
  output logic       tx,
  output logic       done
);
  localparam int CW = $clog2(2*OVS) + 1;

  tx_state_e     state_q;
  logic [CW-1:0] cnt_q, limit;
  logic [2:0]    idx_q, len_q;
  logic [7:0]    sh_q;
  logic          pen_q, par_q, tx_q, done_q;
  logic [1:0]    stop_q;
  logic          last;

  function automatic logic [7:0] keep_bits(input logic [7:0] d, input logic [2:0] lm1);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = d[i] && (i <= int'(lm1));
    return m;
  endfunction

  assign pop  = (state_q == S_IDLE) && tx_en && have_data;
  assign tx   = tx_q;
  assign done = done_q;

  always_comb begin
    if (state_q == S_STOP) limit = CW'((int'(stop_q) + 1) * (OVS/2));
    else                   limit = CW'(OVS);
  end
  assign last = tick && (cnt_q == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      len_q   <= 3'd7;
      sh_q    <= '0;
      pen_q   <= 1'b0;
      par_q   <= 1'b0;
      stop_q  <= 2'd1;
      tx_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q != S_IDLE && tick) cnt_q <= last ? '0 : cnt_q + CW'(1);
      case (state_q)
        S_IDLE: if (pop) begin
          sh_q    <= din;
          len_q   <= cfg.len_m1;
          pen_q   <= cfg.par_en;
          stop_q  <= cfg.stop_sel;
          par_q   <= (^keep_bits(din, cfg.len_m1)) ^ cfg.par_odd;
          cnt_q   <= '0;
          idx_q   <= '0;
          tx_q    <= 1'b0;
          state_q <= S_START;
        end
        S_START: if (last) begin
          tx_q    <= sh_q[0];
          sh_q    <= sh_q >> 1;
          state_q <= S_DATA;
        end
        S_DATA: if (last) begin
          if (idx_q == len_q) begin
            tx_q    <= pen_q ? par_q : 1'b1;
            state_q <= pen_q ? S_PAR : S_STOP;
          end else begin
            idx_q <= idx_q + 3'd1;
            tx_q  <= sh_q[0];
            sh_q  <= sh_q >> 1;
          end
        end
        S_PAR: if (last) begin
          tx_q    <= 1'b1;
          state_q <= S_STOP;
        end
        S_STOP: if (last) begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R5: the line rests high between frames
  a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> tx_q);
  // R4: the stop period is driven high
  a_r4_stop_high: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_STOP) |-> tx_q);
  // R5: no frame starts while the transmitter is off
  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && !tx_en) |=> (state_q == S_IDLE));
endmodule

// File: rtl/sertx_flags.sv
module sertx_flags #(
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] hw_set,
  input  logic [FW-1:0] sw_set,
  input  logic [FW-1:0] sw_clr,
  input  logic [FW-1:0] ien,
  output logic [FW-1:0] flags,
  output logic          irq
);
  logic [FW-1:0] flags_q;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= ((flags_q | sw_set) & ~sw_clr) | hw_set;
      irq_q   <= |(flags_q & ien);
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;

  for (genvar i = 0; i < FW; i++) begin : g_chk
    // R9: a clear without a hardware set removes the flag
    a_r9_clear_takes: assert property (@(posedge clk) disable iff (rst)
      (sw_clr[i] && !hw_set[i]) |=> !flags_q[i]);
  end

  // R10: no enabled flag means no request in the next cycle
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (~|(flags_q & ien)) |=> !irq_q);
endmodule

// File: rtl/sertx_top.sv
module sertx_top import sertx_pkg::*; #(
  parameter int DEPTH = 2,
  parameter int OVS   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              tx_out,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [REG_W-1:0] ctrl_q, frame_q, rd_q, status_w;
  logic             on_q, txc_q;
  logic [FW-1:0]    ien_q, flags, hw_set, sw_set, sw_clr;
  logic             push, accepted, empty, full, pop, done, lvl_w, txc_evt;
  logic [7:0]       fifo_dout;
  logic [CNT_W-1:0] fifo_cnt;
  frame_cfg_t       cfg;

  function automatic logic hit(input logic en, input logic [ADDR_W-1:0] a,
                               input logic [ADDR_W-1:0] r);
    return en && (a == r);
  endfunction

  assign push     = hit(wr_en, wr_addr, ADR_TXDATA);
  assign accepted = push && !full;
  assign cfg      = decode_frame(frame_q);
  assign lvl_w    = ctrl_q[CTRL_LVL] ? empty : !full;
  assign txc_evt  = done && empty && !accepted;

  sertx_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(wr_data[7:0]), .pop(pop),
    .dout(fifo_dout), .empty(empty), .full(full), .count(fifo_cnt)
  );

  sertx_shifter #(.OVS(OVS)) u_shift (
    .clk(clk), .rst(rst), .tick(baud_tick), .tx_en(on_q), .have_data(!empty),
    .din(fifo_dout), .cfg(cfg), .pop(pop), .tx(tx_out), .done(done)
  );

  always_comb begin
    hw_set          = '0;
    hw_set[FL_DONE] = txc_evt;
    hw_set[FL_LVL]  = lvl_w;
    sw_set = hit(wr_en, wr_addr, ADR_FSET) ? (wr_data[FW-1:0] & FLAG_MASK) : '0;
    sw_clr = hit(wr_en, wr_addr, ADR_FCLR) ? wr_data[FW-1:0] : '0;
  end

  sertx_flags #(.FW(FW)) u_flags (
    .clk(clk), .rst(rst), .hw_set(hw_set), .sw_set(sw_set), .sw_clr(sw_clr),
    .ien(ien_q), .flags(flags), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      frame_q <= FRAME_RST;
      on_q    <= 1'b0;
      txc_q   <= 1'b0;
      ien_q   <= '0;
    end else begin
      if (hit(wr_en, wr_addr, ADR_CTRL))  ctrl_q  <= wr_data;
      if (hit(wr_en, wr_addr, ADR_FRAME)) frame_q <= wr_data;
      if (hit(wr_en, wr_addr, ADR_FEN))   ien_q   <= wr_data[FW-1:0] & FLAG_MASK;
      if (hit(wr_en, wr_addr, ADR_CMD)) begin
        if (wr_data[CMD_OFF])     on_q <= 1'b0;
        else if (wr_data[CMD_ON]) on_q <= 1'b1;
      end
      if (accepted)     txc_q <= 1'b0;
      else if (txc_evt) txc_q <= 1'b1;
    end
  end

  always_comb begin
    status_w          = '0;
    status_w[ST_ON]   = on_q;
    status_w[ST_DONE] = txc_q;
    status_w[ST_LVL]  = lvl_w;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (rd_addr)
        ADR_CTRL:   rd_q <= ctrl_q & CTRL_MASK;
        ADR_FRAME:  rd_q <= frame_q & FRAME_MASK;
        ADR_STATUS: rd_q <= status_w;
        ADR_FLAG:   rd_q <= REG_W'(flags);
        ADR_FEN:    rd_q <= REG_W'(ien_q);
        default:    rd_q <= '0;
      endcase
    end
  end
  assign rd_data = rd_q;

  // R8: an accepted character clears the complete status
  a_r8_write_clears: assert property (@(posedge clk) disable iff (rst)
    accepted |=> !txc_q);
  // R5: disable wins over enable in one command
  a_r5_off_wins: assert property (@(posedge clk) disable iff (rst)
    (hit(wr_en, wr_addr, ADR_CMD) && wr_data[CMD_OFF]) |=> !on_q);
  // R7: a full buffer never reports a free slot
  a_r7_full_not_low: assert property (@(posedge clk) disable iff (rst)
    (fifo_cnt == CNT_W'(DEPTH)) |-> !lvl_w);
endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
  localparam int TK  = 4;
  localparam int BIT = 16 * TK;
  localparam int HB  = BIT / 2;

  logic        clk = 1'b0, rst = 1'b1, baud_tick = 1'b0, wr_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic        tx_out, irq;
  int          checks = 0, failures = 0, tick_div = 0;
  longint      cyc = 0;
  bit          finished = 1'b0;

  sertx_top u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tx_out(tx_out), .irq(irq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    tick_div  <= (tick_div == TK-1) ? 0 : tick_div + 1;
    baud_tick <= (tick_div == TK-1);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  function automatic int exp_len(input int f);
    if (f < 2) return 5;
    if (f > 5) return 8;
    return f + 3;
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input int len, input bit odd);
    logic p = odd;
    for (int i = 0; i < len; i++) p ^= d[i];
    return p;
  endfunction

  task automatic get_frame(input int len, input bit pen, output logic [7:0] d,
                           output logic pb, output logic sb, output logic st, output longint t0);
    while (tx_out !== 1'b0) @(negedge clk);
    t0 = cyc;
    repeat (HB) @(negedge clk);
    sb = tx_out;
    d = '0;
    for (int i = 0; i < len; i++) begin
      repeat (BIT) @(negedge clk);
      d[i] = tx_out;
    end
    pb = 1'b0;
    if (pen) begin
      repeat (BIT) @(negedge clk);
      pb = tx_out;
    end
    repeat (HB + 8) @(negedge clk);
    st = tx_out;
  endtask

  task automatic wait_done(output logic [15:0] s);
    for (int i = 0; i < 3000; i++) begin
      rd(4'd3, s);
      if (s[5]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] s;
    logic [7:0]  d, d1, d2;
    logic        pb, sb, st;
    longint      t0, t1;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(tx_out === 1'b1, "R1 line idle", tx_out, 1);
    check(irq === 1'b0, "R1 irq low", irq, 0);
    rd(4'd3, s); check(s == 16'h0040, "R1 status", s, 16'h0040);
    rd(4'd1, s); check(s == 16'h1005, "R1 frame", s, 16'h1005);
    rd(4'd5, s); check(s == 16'h0002, "R9 level flag after reset", s, 2);
    rd(4'd9, s); check(s == 16'h0000, "R11 unmapped read", s, 0);

    // R5 enable
    wr(4'd2, 16'h0004);
    rd(4'd3, s); check(s[1] == 1'b1, "R5 enabled status", s[1], 1);

    // R2 directed 8N1 frame
    wr(4'd4, 16'h00A5);
    get_frame(8, 1'b0, d, pb, sb, st, t0);
    check(sb == 1'b0, "R2 start bit", sb, 0);
    check(d == 8'hA5, "R2 data 8N1", d, 8'hA5);
    check(st == 1'b1, "R4 stop high", st, 1);
    wait_done(s);
    check(s[5] == 1'b1, "R8 complete set", s[5], 1);
    rd(4'd5, s); check(s[0] == 1'b1, "R9 complete flag", s[0], 1);

    // R10 interrupt on enable and off on clear
    wr(4'd8, 16'h0001);
    repeat (2) @(negedge clk);
    check(irq === 1'b1, "R10 irq on", irq, 1);
    wr(4'd7, 16'h0001);
    repeat (2) @(negedge clk);
    check(irq === 1'b0, "R10 irq off after clear", irq, 0);
    rd(4'd5, s); check(s[0] == 1'b0, "R9 clear complete", s[0], 0);

    // R5 disable holds data, R8 clear on write, R7 level modes, R6 drop
    wr(4'd2, 16'h000C);
    rd(4'd3, s); check(s[1] == 1'b0, "R5 disable wins", s[1], 0);
    d1 = 8'h3C; d2 = 8'hC3;
    wr(4'd4, {8'h0, d1});
    rd(4'd3, s);
    check(s[5] == 1'b0, "R8 cleared by write", s[5], 0);
    check(s[6] == 1'b1, "R7 one free slot mode 0", s[6], 1);
    wr(4'd0, 16'h1000);
    rd(4'd3, s); check(s[6] == 1'b0, "R7 not empty mode 1", s[6], 0);
    rd(4'd0, s); check(s == 16'h1000, "R11 ctrl readback", s, 16'h1000);
    wr(4'd0, 16'h0000);
    wr(4'd4, {8'h0, d2});
    rd(4'd3, s); check(s[6] == 1'b0, "R7 full mode 0", s[6], 0);
    wr(4'd4, 16'h0077);
    repeat (300) @(negedge clk);
    check(tx_out === 1'b1, "R5 line high while off", tx_out, 1);
    wr(4'd2, 16'h0004);
    get_frame(8, 1'b0, d, pb, sb, st, t0);
    check(d == d1, "R6 first in order", d, d1);
    get_frame(8, 1'b0, d, pb, sb, st, t1);
    check(d == d2, "R6 second in order", d, d2);
    check((t1 - t0) >= 634 && (t1 - t0) <= 646, "R4 one stop spacing", t1 - t0, 640);
    t0 = cyc;
    while (tx_out === 1'b1 && (cyc - t0) < 900) @(negedge clk);
    check(tx_out === 1'b1, "R6 dropped write not sent", tx_out, 1);
    rd(4'd3, s); check(s[5] == 1'b1, "R8 complete after burst", s[5], 1);

    // R4 stop lengths via back-to-back spacing
    for (int sel = 0; sel < 4; sel++) begin
      longint ex;
      wr(4'd2, 16'h0008);
      wr(4'd1, 16'((sel << 12) | 5));
      wr(4'd4, 16'h0055);
      wr(4'd4, 16'h00AA);
      wr(4'd2, 16'h0004);
      get_frame(8, 1'b0, d, pb, sb, st, t0);
      get_frame(8, 1'b0, d, pb, sb, st, t1);
      ex = 9 * BIT + (sel + 1) * 8 * TK;
      check((t1 - t0) >= ex - 6 && (t1 - t0) <= ex + 6, $sformatf("R4 stop sel %0d", sel), t1 - t0, ex);
      wait_done(s);
    end

    // R2/R3 random frames
    for (int it = 0; it < 30; it++) begin
      int lf, pc, sl, len;
      logic [7:0] dat, m;
      lf  = int'($urandom_range(0, 7));
      pc  = int'($urandom_range(0, 3));
      sl  = int'($urandom_range(0, 3));
      dat = 8'($urandom);
      len = exp_len(lf);
      m   = 8'((1 << len) - 1);
      wr(4'd1, 16'((sl << 12) | (pc << 8) | lf));
      wr(4'd4, {8'h0, dat});
      get_frame(len, pc[1], d, pb, sb, st, t0);
      check(d == (dat & m), $sformatf("R2 data len %0d", len), d, dat & m);
      if (pc[1]) check(pb == exp_par(dat, len, pc[0]), "R3 parity bit", pb, exp_par(dat, len, pc[0]));
      check(st == 1'b1, "R4 stop bit", st, 1);
      wait_done(s);
    end

    // R9 software set/clear
    wr(4'd7, 16'h001F);
    rd(4'd5, s); check(s == 16'h0002, "R9 clear all, level re-set", s, 2);
    wr(4'd6, 16'h001C);
    rd(4'd5, s); check(s == 16'h0016, "R9 set bits, bit3 zero", s, 16'h16);
    wr(4'd8, 16'h0010);
    repeat (2) @(negedge clk);
    check(irq === 1'b1, "R10 irq from software flag", irq, 1);
    wr(4'd7, 16'h0014);
    rd(4'd5, s); check(s == 16'h0002, "R9 clear software bits", s, 2);
    check(irq === 1'b0, "R10 irq drops", irq, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule